// File: doc/BRIEF.md
# Multiplexed Address/Data Register Bus Slave

This block is the slave side of a register bus that an external controller uses to read and write a small set of internal registers. A single 16-bit bus carries the address and then the data. An address strobe captures the address from the bus. Address bit 1 comes from its own pin instead of from the bus. Bus bits 1 and 0 are ignored, so every access moves a full 16-bit word. Chip select and a direction pin frame each access. The block answers with an active-low ready that ends the cycle. It drives the shared bus only while it is answering a read.

The chip select and the direction pin are asynchronous to the internal clock, so the block synchronizes them first. A sequencer then runs through four states: `ST_IDLE`, `ST_WAIT`, `ST_ACCESS` and `ST_DONE`. Its transitions are:
- start: `ST_IDLE` to `ST_WAIT`, when the synchronized chip select becomes active.
- abort: `ST_WAIT` to `ST_IDLE`, when select drops during the wait.
- settle: `ST_WAIT` to `ST_ACCESS`, after `LAT` cycles.
- commit: `ST_ACCESS` to `ST_DONE`, always after one cycle.
- release: `ST_DONE` to `ST_IDLE`, when the synchronized select goes inactive.

A style pin inverts the meaning of the direction pin, so that two families of controller can attach. A control bit selects byte order. The register file holds:
- a read-only identity word;
- a control word with the byte-order bit and a self-clearing soft-reset bit;
- an interrupt status register with write-one-to-clear bits;
- an interrupt mask register;
- four scratch words.

The interrupt request is an open-drain, active-low output, modelled here as a pull-down enable.

Top module: `regbus_slave`

## Requirements
- R1: After reset: `rdy_n` is 1, `ad_oe` is 0, `irq_pull` is 0 and `soft_rst` is 0. Reading index 0 returns `DEV_ID` (default 16'hA5C3). Reading the control word (index 1) returns 0, which means big-endian order.
- R2: The register index is `{bus[15:2], a1}`, taken from `ad_in` and the `a1` pin while `ale` is high at a clock edge. Bus bits 1 and 0 have no effect on which register is accessed.
- R3: `rdy_n` falls exactly `SYNC_STAGES+LAT+2` rising clock edges (6 by default) after `cs_n` is driven low. It returns to 1 as soon as `cs_n` is high, without waiting for a clock.
- R4: `ad_oe` is 1 only while `rdy_n` is low, `cs_n` is low and the access is a read. It stays 0 throughout a write. It is 0 once `cs_n` returns high.
- R5: A 16-bit word written to a scratch register (indices 4 to 7) reads back unchanged, and each index holds its own value.
- R6: Control bit 0 selects byte order; 0 means big endian. When it is 1, the two bytes of every written word and every read word are exchanged at the bus, both for the control word itself and for the other registers.
- R7: With `ctl_style`=0, `wr_rd`=1 means a write. With `ctl_style`=1, `wr_rd`=0 means a write.
- R8: An event input bit that is 1 for one cycle sets the matching bit of the interrupt status register (index 2). A status bit clears only when a write to index 2 carries a 1 at that position.
- R9: `irq_pull` is 1 exactly when some status bit and the same bit of the mask register (index 3, reset 0) are both 1.
- R10: Writing a word with bit 1 set to the control word produces a pulse on `soft_rst` that is high for exactly one clock. Bit 1 always reads back as 0.
- R11: Writes to index 0, and to any index above 7, have no effect. Reads of an index above 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address latch strobe |
| a1 | input | 1 | Address bit 1, dedicated pin |
| cs_n | input | 1 | Active-low chip select |
| wr_rd | input | 1 | Access direction, polarity chosen by ctl_style |
| ctl_style | input | 1 | Controller bus style select |
| ad_in | input | 16 | Bus value seen at the pins |
| ad_out | output | 16 | Read data for the bus |
| ad_oe | output | 1 | Bus output enable (high impedance when 0) |
| rdy_n | output | 1 | Active-low ready, ends the cycle |
| irq_pull | output | 1 | Pull the open-drain interrupt line low |
| evt_in | input | 8 | Event pulses that set status bits |
| soft_rst | output | 1 | One-cycle reset pulse to the rest of the device |

## Verification
The main function is tried with writes followed by reads in several patterns:
- Neighbouring indices that differ only in the `a1` pin, with the ignored low bus bits set to ones. This separates the dedicated address pin from bus bit 1.
- The same scratch word written in little-endian order and read in big-endian order. This shows whether the swap is applied in each direction.
- An access in each bus style. A design that ignores the style pin turns the write into a read, so the readback does not match.
- Event pulses with the mask clear, then with one bit unmasked, then with a write-one-to-clear. Together these separate status from mask from the interrupt output.
- The exact edge count to ready is measured on every access.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACCESS,
        ST_DONE
    } bus_state_t;

    localparam int unsigned IDX_ID   = 0;
    localparam int unsigned IDX_CTRL = 1;
    localparam int unsigned IDX_STAT = 2;
    localparam int unsigned IDX_MASK = 3;
    localparam int unsigned IDX_GP0  = 4;

    localparam int unsigned CTRL_LITTLE_BIT = 0;
    localparam int unsigned CTRL_SRST_BIT   = 1;

endpackage

// File: rtl/regbus_sync.sv
module regbus_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/regbus_fsm.sv
module regbus_fsm
    import regbus_pkg::*;
#(
    parameter int unsigned LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic cs_n_raw,
    input  logic rd_dir,
    output logic wr_en,
    output logic cap_en,
    output logic rdy_n,
    output logic bus_oe
);

    localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;

    bus_state_t     state;
    bus_state_t     nxt;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_WAIT) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cs_act) nxt = ST_WAIT;
            ST_WAIT: begin
                if (!cs_act)                  nxt = ST_IDLE;
                else if (cnt == CW'(LAT - 1)) nxt = ST_ACCESS;
            end
            ST_ACCESS: nxt = ST_DONE;
            ST_DONE:   if (!cs_act) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_en  = (state == ST_ACCESS) && !rd_dir;
        cap_en = (state == ST_ACCESS) && rd_dir;
        rdy_n  = !((state == ST_DONE) && !cs_n_raw);
        bus_oe = (state == ST_DONE) && !cs_n_raw && rd_dir;
    end

endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile
    import regbus_pkg::*;
#(
    parameter int unsigned      DATA_W  = 16,
    parameter int unsigned      IDX_W   = 15,
    parameter int unsigned      NUM_EVT = 8,
    parameter int unsigned      NUM_GP  = 4,
    parameter logic [DATA_W-1:0] DEV_ID = 16'hA5C3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [DATA_W-1:0]  rdata,
    output logic               little_end,
    output logic               soft_rst,
    output logic [NUM_EVT-1:0] status,
    output logic               irq_pull
);

    logic [NUM_EVT-1:0] mask;
    logic [DATA_W-1:0]  gp [NUM_GP];
    logic               hit_ctrl, hit_stat, hit_mask;

    assign hit_ctrl = (idx == IDX_W'(IDX_CTRL));
    assign hit_stat = (idx == IDX_W'(IDX_STAT));
    assign hit_mask = (idx == IDX_W'(IDX_MASK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            little_end <= 1'b0;
            soft_rst   <= 1'b0;
            mask       <= '0;
            status     <= '0;
        end else begin
            soft_rst <= wr_en && hit_ctrl && wdata[CTRL_SRST_BIT];
            if (wr_en && hit_ctrl) little_end <= wdata[CTRL_LITTLE_BIT];
            if (wr_en && hit_mask) mask <= wdata[NUM_EVT-1:0];
            status <= (status & ~((wr_en && hit_stat) ? wdata[NUM_EVT-1:0] : '0)) | evt_in;
        end
    end

    generate
        for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) gp[g] <= '0;
                else if (wr_en && idx == IDX_W'(IDX_GP0 + g)) gp[g] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (idx == IDX_W'(IDX_ID)) begin
            rdata = DEV_ID;
        end else if (hit_ctrl) begin
            rdata[CTRL_LITTLE_BIT] = little_end;
        end else if (hit_stat) begin
            rdata[NUM_EVT-1:0] = status;
        end else if (hit_mask) begin
            rdata[NUM_EVT-1:0] = mask;
        end else begin
            for (int g = 0; g < NUM_GP; g++) begin
                if (idx == IDX_W'(IDX_GP0 + g)) rdata = gp[g];
            end
        end
    end

    assign irq_pull = |(status & mask);

endmodule

// File: rtl/regbus_slave.sv
module regbus_slave
    import regbus_pkg::*;
#(
    parameter int unsigned       DATA_W      = 16,
    parameter int unsigned       NUM_EVT     = 8,
    parameter int unsigned       NUM_GP      = 4,
    parameter int unsigned       LAT         = 2,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] DEV_ID      = 16'hA5C3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ale,
    input  logic               a1,
    input  logic               cs_n,
    input  logic               wr_rd,
    input  logic               ctl_style,
    input  logic [DATA_W-1:0]  ad_in,
    output logic [DATA_W-1:0]  ad_out,
    output logic               ad_oe,
    output logic               rdy_n,
    output logic               irq_pull,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               soft_rst
);

    localparam int unsigned IDX_W  = DATA_W - 1;
    localparam int unsigned NBYTES = DATA_W / 8;

    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        sync_q;
    logic              cs_act, rd_dir;
    logic              wr_en, cap_en;
    logic              little_end;
    logic [DATA_W-1:0] bus_swapped, rd_swapped, wdata, rdata, rd_q;
    logic [NUM_EVT-1:0] int_status;
    logic              unused_low_bits;

    assign unused_low_bits = &{1'b0, ad_in[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   idx_q <= '0;
        else if (ale) idx_q <= {ad_in[DATA_W-1:2], a1};
    end

    regbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({~cs_n, wr_rd}),
        .q     (sync_q)
    );

    assign cs_act = sync_q[1];
    assign rd_dir = ~(sync_q[0] ^ ctl_style);

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_swap
            assign bus_swapped[b*8 +: 8] = ad_in[(NBYTES-1-b)*8 +: 8];
            assign rd_swapped[b*8 +: 8]  = rdata[(NBYTES-1-b)*8 +: 8];
        end
    endgenerate

    assign wdata = little_end ? bus_swapped : ad_in;

    regbus_fsm #(.LAT(LAT)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .cs_n_raw (cs_n),
        .rd_dir   (rd_dir),
        .wr_en    (wr_en),
        .cap_en   (cap_en),
        .rdy_n    (rdy_n),
        .bus_oe   (ad_oe)
    );

    regbus_regfile #(
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .NUM_EVT (NUM_EVT),
        .NUM_GP  (NUM_GP),
        .DEV_ID  (DEV_ID)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .idx        (idx_q),
        .wdata      (wdata),
        .evt_in     (evt_in),
        .rdata      (rdata),
        .little_end (little_end),
        .soft_rst   (soft_rst),
        .status     (int_status),
        .irq_pull   (irq_pull)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_q <= '0;
        else if (cap_en) rd_q <= little_end ? rd_swapped : rdata;
    end

    assign ad_out = rd_q;

endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
    parameter int unsigned NUM_EVT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               rdy_n,
    input logic               ad_oe,
    input logic               soft_rst,
    input logic               wr_en,
    input logic [NUM_EVT-1:0] status
);

    // R3
    rdy_after_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(!cs_n));

    // R4
    drive_only_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!rdy_n && !cs_n));

    // R5
    write_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !cs_n);

    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (($past(status) & ~status) == '0));

    // R10
    soft_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

endmodule

bind regbus_slave regbus_slave_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rdy_n    (rdy_n),
    .ad_oe    (ad_oe),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .status   (int_status)
);

// File: tb/regbus_slave_test.sv
module regbus_slave_test;

    localparam int unsigned EXP_EDGES = 2 + 2 + 2;  // SYNC_STAGES + LAT + 2

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ale = 0, a1 = 0, cs_n = 1, wr_rd = 0, ctl_style = 0;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe, rdy_n, irq_pull, soft_rst;
    logic [7:0]  evt_in = '0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    logic [15:0] act_q[$];
    string       tag_q[$];
    logic [15:0] mon_a, mon_e;
    string       mon_t;

    regbus_slave uut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .a1(a1), .cs_n(cs_n),
        .wr_rd(wr_rd), .ctl_style(ctl_style), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .rdy_n(rdy_n),
        .irq_pull(irq_pull), .evt_in(evt_in), .soft_rst(soft_rst)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            mon_a = act_q.pop_front();
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            check(mon_a === mon_e, mon_t, {16'h0, mon_a}, {16'h0, mon_e});
        end
    end

    task automatic bus_op(input bit do_wr, input int idx, input logic [15:0] wdat,
                          output logic [15:0] rdat, output bit oe, output bit srst,
                          output int edges);
        logic [14:0] ix;
        ix = idx[14:0];
        @(negedge clk);
        ale   = 1;
        a1    = ix[0];
        ad_in = {ix[14:1], 2'b11};   // low bits set to show they are ignored (R2)
        @(negedge clk);
        ale   = 0;
        ad_in = do_wr ? wdat : 16'h0;
        wr_rd = do_wr ? ~ctl_style : ctl_style;
        cs_n  = 0;
        edges = 0;
        while (rdy_n && edges < 50) begin
            @(posedge clk);
            #1;
            edges++;
        end
        rdat = ad_out;
        oe   = ad_oe;
        srst = soft_rst;
        @(negedge clk);
        cs_n = 1;
        #1;
        check(rdy_n === 1'b1, "R3 ready released with select", {31'h0, rdy_n}, 1);
        check(ad_oe === 1'b0, "R4 bus released after select", {31'h0, ad_oe}, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [15:0] d);
        logic [15:0] r;
        bit oe, sr;
        int e;
        bus_op(1'b1, idx, d, r, oe, sr, e);
        check(!oe, "R4 no drive during write", {31'h0, oe}, 0);
    endtask

    task automatic rd_exp(input int idx, input logic [15:0] e, input string tag);
        logic [15:0] r;
        bit oe, sr;
        int n;
        bus_op(1'b0, idx, 16'h0, r, oe, sr, n);
        check(oe, "R4 drive during read", {31'h0, oe}, 1);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        act_q.push_back(r);
    endtask

    task automatic summary;
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        bit oe, sr;
        int edges;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(rdy_n === 1'b1, "R1 rdy_n after reset", {31'h0, rdy_n}, 1);
        check(ad_oe === 1'b0, "R1 ad_oe after reset", {31'h0, ad_oe}, 0);
        check(irq_pull === 1'b0, "R1 irq after reset", {31'h0, irq_pull}, 0);
        check(soft_rst === 1'b0, "R1 soft_rst after reset", {31'h0, soft_rst}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R3 latency, measured on an identity read
        bus_op(1'b0, 0, 16'h0, r, oe, sr, edges);
        check(edges == EXP_EDGES, "R3 ready latency", edges, EXP_EDGES);
        check(r === 16'hA5C3, "R1 identity word", {16'h0, r}, 32'hA5C3);
        rd_exp(1, 16'h0000, "R1 control reset value big endian");

        // R5 / R2 scratch round trip, neighbours differ in a1 only
        wr(4, 16'h1234);
        wr(5, 16'hBEEF);
        rd_exp(4, 16'h1234, "R5 scratch 4");
        rd_exp(5, 16'hBEEF, "R2 a1 selects index 5");

        // R11 read-only and unmapped
        wr(0, 16'h0000);
        rd_exp(0, 16'hA5C3, "R11 identity write ignored");
        wr(20, 16'hFFFF);
        rd_exp(20, 16'h0000, "R11 unmapped reads zero");
        rd_exp(4, 16'h1234, "R11 unmapped write leaves scratch");

        // R6 byte order
        wr(1, 16'h0001);
        rd_exp(1, 16'h0100, "R6 control read swapped");
        wr(6, 16'h1234);
        rd_exp(6, 16'h1234, "R6 little round trip");
        wr(1, 16'h0000);
        rd_exp(6, 16'h3412, "R6 stored swapped seen in big");

        // R7 bus style
        ctl_style = 1;
        wr(7, 16'h5A5A);
        rd_exp(7, 16'h5A5A, "R7 style1 round trip");
        ctl_style = 0;
        rd_exp(7, 16'h5A5A, "R7 style0 sees style1 write");

        // R8 / R9 interrupts
        @(negedge clk) evt_in = 8'h05;
        @(negedge clk) evt_in = 8'h00;
        @(negedge clk);
        check(irq_pull === 1'b0, "R9 masked events no irq", {31'h0, irq_pull}, 0);
        rd_exp(2, 16'h0005, "R8 status set by events");
        wr(3, 16'h0004);
        check(irq_pull === 1'b1, "R9 unmasked status raises irq", {31'h0, irq_pull}, 1);
        wr(2, 16'h0004);
        check(irq_pull === 1'b0, "R9 irq drops after clear", {31'h0, irq_pull}, 0);
        rd_exp(2, 16'h0001, "R8 write one clears only that bit");

        // R10 soft reset pulse
        bus_op(1'b1, 1, 16'h0002, r, oe, sr, edges);
        check(sr, "R10 soft reset pulse seen", {31'h0, sr}, 1);
        check(soft_rst === 1'b0, "R10 soft reset pulse ended", {31'h0, soft_rst}, 0);
        rd_exp(1, 16'h0000, "R10 soft reset bit reads zero");

        finished = 1;
        summary();
    end

endmodule